// File: doc/BRIEF.md
# Memory Window Control Register and Address Decoder

This block holds a single 64-bit control word that places a device's local memory at a chosen location inside a 60-bit host real address space. It also decodes incoming real addresses against that window. Software reaches the word through a small register port, which carries an offset, a 64-bit data bus with byte enables, a write strobe and a privilege flag. The control word uses MSB-first bit numbering, where bit 0 is the most significant bit. Bit 0 enables the window, bits 4 to 51 give the window base, and bits 58 to 63 hold a log2-encoded size code.

The decoder takes a real address and, one clock later, presents a hit flag and the byte offset of that address inside the window. The window holds 2^(12+size) bytes and is never smaller than 4 KB. Two build-time options shape the block. The first decides whether the feature exists at all; without it, the block reads as all zeros, so software can probe for it. The second sets the implemented real address width, and base bits above that width are dropped.

Top module: `memwin_regdec`

## Requirements
- R1: A write to the register offset (default 0x10) stores the control word. In LSB-0 terms, bit 63 is the enable, bits 59:12 are the base (address bits 59:12) and bits 5:0 are the size code. A read at that offset returns the stored word combinationally.
- R2: The reserved positions, LSB-0 bits 62:60 and 11:6, always read back as 0, whatever value was written to them.
- R3: A write is taken only when all four of these hold: the write strobe is high, the privilege flag is high, all eight byte enables are set, and the offset matches. In every other case the stored word stays unchanged.
- R4: A read at any offset other than the register offset returns zero.
- R5: When the feature is built absent, every read returns zero, writes have no effect, and the hit flag never rises.
- R6: Base bits at address positions at or above the implemented real address width RA_WIDTH are stored as 0 and read as 0.
- R7: Writing the probe pattern 0x0FFFFFFFFFFFF03F reads back nonzero when the feature is present. With RA_WIDTH=60 the read value equals the pattern. When the feature is absent, the read value is zero.
- R8: One cycle after an address is presented, the hit flag is 1 exactly when two conditions hold: the enable is 1, and address bits 59 down to 12+size equal the same bits of the base. The base bits inside the window take no part in the comparison, so a misaligned base behaves as though those bits were zero.
- R9: On a hit, the 40-bit offset output equals the address bits below 12+size, with all higher bits 0. On a miss, the offset is 0.
- R10: A size code above 28 decodes exactly like a size code of 28, which gives a 2^40-byte window.
- R11: While the enable is 0, the hit flag stays 0 and the offset stays 0.
- R12: Reset clears the stored word, the hit flag and the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | OFS_W (8) | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_priv | input | 1 | Access is privileged |
| reg_be | input | 8 | Byte enables; all must be set for a write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from reg_addr |
| dec_addr | input | 60 | Real address to decode |
| dec_hit | output | 1 | Registered: address falls in the enabled window |
| dec_offset | output | 40 | Registered: byte offset inside the window |

## Verification
The bench builds three copies side by side, all driven by the same stimulus. The first has the feature present and the full 60-bit real address. The second has the feature present but only 44 implemented address bits. The third is built with the feature absent. The 44-bit copy shows which base bits are dropped and how the probe readback shrinks. The absent copy shows the all-zero behaviour and the never-hit decoder for every write and address that the full copy handles. Random control words, including size codes above 28, misaligned bases and rejected writes, are mixed with addresses drawn near each window edge.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int ADDR_W    = 60;
    localparam int MIN_SHIFT = 12;
    localparam int SIZE_W    = 6;
    localparam int MAX_SIZE  = 28;
    localparam int WORD_W    = 64;
    localparam int BE_W      = WORD_W / 8;
    localparam int BASE_W    = ADDR_W - MIN_SHIFT;
    localparam int OFF_W     = MIN_SHIFT + MAX_SIZE;
    localparam int LIM_W     = $clog2(ADDR_W + 1);
    // LSB-0 positions of the MSB-first fields
    localparam int EN_POS    = WORD_W - 1;
    localparam int BASE_LSB  = MIN_SHIFT;
    localparam int BASE_MSB  = ADDR_W - 1;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
    } win_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] offset;
    } dec_out_t;

    function automatic win_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        win_cfg_t c;
        c.en   = w[EN_POS];
        c.base = w[BASE_MSB:BASE_LSB];
        c.size = w[SIZE_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input win_cfg_t c);
        logic [WORD_W-1:0] w;
        w                    = '0;
        w[EN_POS]            = c.en;
        w[BASE_MSB:BASE_LSB] = c.base;
        w[SIZE_W-1:0]        = c.size;
        return w;
    endfunction
endpackage

// File: rtl/memwin_csr.sv
module memwin_csr
    import memwin_pkg::*;
#(
    parameter bit FEATURE_EN = 1'b1,
    parameter int RA_WIDTH   = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic              wr_priv,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output win_cfg_t          cfg_q
);
    typedef struct packed {
        win_cfg_t cfg;
    } csr_state_t;

    csr_state_t        st_d, st_q;
    logic [BASE_W-1:0] base_keep;
    logic              accept;

    always_comb begin
        for (int i = 0; i < BASE_W; i++) begin
            base_keep[i] = (i + MIN_SHIFT) < RA_WIDTH;
        end
    end

    always_comb begin
        st_d   = st_q;
        accept = wr_en && wr_sel && wr_priv && (&wr_be);
        if (accept) begin
            st_d.cfg      = word_to_cfg(wr_data);
            st_d.cfg.base = st_d.cfg.base & base_keep;
            if (!FEATURE_EN) begin
                st_d.cfg = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    // R3: only a full, privileged, selected write may change the word
    a_r3_reject_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !wr_sel || !wr_priv || !(&wr_be)) |=> $stable(cfg_q));

    generate
        if (RA_WIDTH < ADDR_W) begin : g_narrow
            // R6: unimplemented base bits never hold a one
            a_r6_upper_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_q.base[BASE_W-1:RA_WIDTH-MIN_SHIFT] == '0);
        end
        if (!FEATURE_EN) begin : g_absent
            // R5: nothing is ever stored without the feature
            a_r5_absent_empty: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_q == '0);
        end
    endgenerate
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_q,
    output logic [OFF_W-1:0]  offset_q
);
    typedef struct packed {
        dec_out_t out;
    } dec_state_t;

    dec_state_t        st_d, st_q;
    logic [SIZE_W-1:0] size_eff;
    logic [LIM_W-1:0]  lim;
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] base_full;
    logic              match;

    always_comb begin
        size_eff  = (cfg.size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : cfg.size;
        lim       = LIM_W'(MIN_SHIFT) + LIM_W'(size_eff);
        for (int i = 0; i < ADDR_W; i++) begin
            keep[i] = LIM_W'(i) >= lim;
        end
        base_full = {cfg.base, {MIN_SHIFT{1'b0}}};
        match     = ((addr ^ base_full) & keep) == '0;
        st_d      = '0;
        if (cfg.en && match) begin
            st_d.out.hit    = 1'b1;
            st_d.out.offset = addr[OFF_W-1:0] & ~keep[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_q    = st_q.out.hit;
    assign offset_q = st_q.out.offset;

    // R11: a disabled window cannot produce a hit on the next cycle
    a_r11_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !hit_q);

    // R9: a miss carries no offset
    a_r9_miss_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> offset_q == '0);

    // R8: every hit traces back to an enabled window
    a_r8_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(cfg.en));
endmodule

// File: rtl/memwin_regdec.sv
module memwin_regdec
    import memwin_pkg::*;
#(
    parameter bit            FEATURE_EN = 1'b1,
    parameter int            RA_WIDTH   = 60,
    parameter int            OFS_W      = 8,
    parameter logic [OFS_W-1:0] REG_OFS = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic              reg_priv,
    input  logic [7:0]        reg_be,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [59:0]       dec_addr,
    output logic              dec_hit,
    output logic [39:0]       dec_offset
);
    win_cfg_t cfg_q;
    logic     sel;

    assign sel = (reg_addr == REG_OFS);

    memwin_csr #(
        .FEATURE_EN (FEATURE_EN),
        .RA_WIDTH   (RA_WIDTH)
    ) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (sel),
        .wr_priv (reg_priv),
        .wr_be   (reg_be),
        .wr_data (reg_wdata),
        .cfg_q   (cfg_q)
    );

    memwin_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .addr     (dec_addr),
        .hit_q    (dec_hit),
        .offset_q (dec_offset)
    );

    always_comb begin
        reg_rdata = '0;
        if (FEATURE_EN && sel) begin
            reg_rdata = cfg_to_word(cfg_q);
        end
    end

    // R2: reserved positions read as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[62:60] == 3'b000) && (reg_rdata[11:6] == 6'b000000));

    // R4: reads elsewhere return nothing
    a_r4_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> reg_rdata == '0);
endmodule

// File: tb/memwin_regdec_tb.sv
`timescale 1ns/1ps
module memwin_regdec_tb_top;
    localparam logic [7:0]  OFS   = 8'h10;
    localparam logic [63:0] PROBE = 64'h0FFF_FFFF_FFFF_F03F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = OFS;
    logic        reg_wr = 1'b0, reg_priv = 1'b0;
    logic [7:0]  reg_be = 8'h00;
    logic [63:0] reg_wdata = '0;
    logic [59:0] dec_addr = '0;
    logic [63:0] rd_i, rd_m, rd_n;
    logic        hit_i, hit_m, hit_n;
    logic [39:0] off_i, off_m, off_n;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [63:0] sh_i = '0, sh_m = '0, sh_n = '0;

    always #4 clk = ~clk;

    memwin_regdec #(.FEATURE_EN(1'b1), .RA_WIDTH(60)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_i), .dec_addr(dec_addr),
        .dec_hit(hit_i), .dec_offset(off_i));
    memwin_regdec #(.FEATURE_EN(1'b1), .RA_WIDTH(44)) dut_m (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_m), .dec_addr(dec_addr),
        .dec_hit(hit_m), .dec_offset(off_m));
    memwin_regdec #(.FEATURE_EN(1'b0), .RA_WIDTH(60)) dut_n (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_priv(reg_priv),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(rd_n), .dec_addr(dec_addr),
        .dec_hit(hit_n), .dec_offset(off_n));

    function automatic logic [63:0] exp_store(input logic [63:0] w, input bit feat, input int m);
        logic [63:0] r;
        if (!feat) return '0;
        r = w & 64'h8FFF_FFFF_FFFF_F03F;
        for (int i = m; i < 60; i++) r[i] = 1'b0;
        return r;
    endfunction

    function automatic logic [40:0] exp_dec(input logic [63:0] r, input logic [59:0] a);
        int s;
        int lim;
        logic [63:0] base, diff, msk;
        s    = int'(r[5:0]);
        if (s > 28) s = 28;
        lim  = 12 + s;
        base = {4'h0, r[59:12], 12'h000};
        diff = ({4'h0, a} ^ base) >> lim;
        msk  = (64'd1 << lim) - 64'd1;
        if (r[63] && diff == 0) return {1'b1, 40'(({4'h0, a}) & msk)};
        return '0;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be,
                            input logic pv);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_priv = pv; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_priv = 1'b0; reg_be = 8'h00;
        if (a == OFS && pv && be == 8'hFF) begin
            sh_i = exp_store(d, 1'b1, 60);
            sh_m = exp_store(d, 1'b1, 44);
            sh_n = exp_store(d, 1'b0, 60);
        end
    endtask

    task automatic check_reads(input string req);
        reg_addr = OFS;
        #1;
        chk(req, "read full", rd_i, sh_i);
        chk(req, "read narrow R6", rd_m, sh_m);
        chk(req, "read absent R5", rd_n, sh_n);
    endtask

    task automatic do_dec(input logic [59:0] a, input string req);
        logic [40:0] e;
        @(negedge clk);
        dec_addr = a;
        @(negedge clk);
        e = exp_dec(sh_i, a);
        chk(req, "hit full", {63'd0, hit_i}, {63'd0, e[40]});
        chk(req, "offset full", {24'd0, off_i}, {24'd0, e[39:0]});
        e = exp_dec(sh_m, a);
        chk(req, "hit narrow", {63'd0, hit_m}, {63'd0, e[40]});
        chk(req, "offset narrow", {24'd0, off_m}, {24'd0, e[39:0]});
        chk("R5", "hit absent", {63'd0, hit_n}, 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] w, base;
        logic [59:0] a;
        void'($urandom(32'd7719));
        dec_addr = 60'h0FF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "rdata in reset", rd_i, 64'd0);
        chk("R12", "hit in reset", {63'd0, hit_i}, 64'd0);
        chk("R12", "offset in reset", {24'd0, off_i}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_reads("R12");

        // R7: probe pattern
        do_write(OFS, PROBE, 8'hFF, 1'b1);
        check_reads("R7");
        chk("R7", "probe full equals pattern", rd_i, PROBE);
        chk("R7", "probe narrow", rd_m, 64'h0000_0FFF_FFFF_F03F);
        chk("R7", "probe absent", rd_n, 64'd0);

        // R2 / R1: all ones written, reserved positions drop
        do_write(OFS, '1, 8'hFF, 1'b1);
        check_reads("R2");
        chk("R2", "all ones full", rd_i, 64'h8FFF_FFFF_FFFF_F03F);

        // R4: other offset reads zero, write there ignored
        reg_addr = 8'h18; #1;
        chk("R4", "other offset read", rd_i, 64'd0);
        do_write(8'h18, 64'h8000_0000_0000_0001, 8'hFF, 1'b1);
        check_reads("R3");

        // R3: unprivileged and partial writes ignored
        do_write(OFS, 64'h8000_0000_1234_5000, 8'hFF, 1'b0);
        check_reads("R3");
        do_write(OFS, 64'h8000_0000_1234_5000, 8'h7F, 1'b1);
        check_reads("R3");

        // R8 / R9: size 0 window edges
        do_write(OFS, 64'h8000_0000_1234_5000, 8'hFF, 1'b1);
        check_reads("R1");
        do_dec(60'h0000_0001_2345_000, "R8");
        do_dec(60'h0000_0001_2345_FFF, "R9");
        do_dec(60'h0000_0001_2346_000, "R8");
        do_dec(60'h0000_0001_2344_FFF, "R8");

        // R10: size 63 behaves as 28
        do_write(OFS, 64'h8000_0100_0000_003F, 8'hFF, 1'b1);
        do_dec(60'h0000_01FF_FFFF_FFF, "R10");
        do_dec(60'h0000_0200_0000_000, "R10");
        do_dec(60'h0000_00FF_FFFF_FFF, "R10");

        // R8: misaligned base acts aligned
        do_write(OFS, 64'h8000_0000_1234_7004, 8'hFF, 1'b1);
        do_dec(60'h0000_0001_2340_010, "R8");

        // R11: enable clear
        do_write(OFS, 64'h0000_0000_1234_5000, 8'hFF, 1'b1);
        do_dec(60'h0000_0001_2345_010, "R11");

        // random mix
        for (int k = 0; k < 200; k++) begin
            int kind;
            w = {$urandom, $urandom};
            w[5:0] = 6'($urandom_range(0, 35));
            w[63] = ($urandom_range(0, 3) != 0);
            kind = $urandom_range(0, 7);
            case (kind)
                0: do_write(OFS, w, 8'hFF, 1'b0);
                1: do_write(OFS, w, 8'($urandom_range(0, 254)), 1'b1);
                2: do_write(8'h08, w, 8'hFF, 1'b1);
                default: do_write(OFS, w, 8'hFF, 1'b1);
            endcase
            check_reads(kind < 3 ? "R3" : "R1");
            for (int j = 0; j < 3; j++) begin
                int pick;
                int bitn;
                pick = $urandom_range(0, 3);
                base = (pick == 1) ? {4'h0, sh_m[59:12], 12'h000} : {4'h0, sh_i[59:12], 12'h000};
                a = 60'(base) ^ 60'({$urandom, $urandom} & 64'h0000_00FF_FFFF_FFFF >> $urandom_range(0, 28));
                if (pick == 2) begin
                    bitn = $urandom_range(12, 59);
                    a[bitn] = ~a[bitn];
                end
                if (pick == 3) a = 60'({$urandom, $urandom});
                do_dec(a, "R8");
            end
        end

        // R12: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        sh_i = '0; sh_m = '0; sh_n = '0;
        #1;
        check_reads("R12");
        chk("R12", "hit after reset", {63'd0, hit_i}, 64'd0);
        rst_n = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule